// File: doc/BRIEF.md
# Flash Status Register and Block Protection Unit

This block keeps the software-visible status byte of a serial flash device and answers, every cycle, whether an address lies inside the region that the protection bits shield from program and erase. A command sequencer, which sits outside this block, decodes opcodes. It hands the block one command code per cycle: set or clear the write-enable latch, arm a status write, or write the status byte with a data byte. It also pulses when an internal program or erase operation starts and ends, and when auto-increment programming mode is entered or left.

A status write needs two things. The previous command must have been the arm-status-write command. The protection fields must also be unlocked, which means the active-low write-protect pin is high or the lock bit is 0. The busy flag, the write-enable latch and the auto-increment flag cannot be changed through a status write. The status byte stays readable while an operation is running, so the sequencer can poll for completion.

Top module: `flash_status_unit`

## Requirements
- R1: When `rst` is sampled high, the status byte on `status_out` becomes 8'h8C on the next cycle. Its layout is: bit 0 busy, bit 1 write-enable latch, bits 3:2 protection field, bit 6 auto-increment flag, bit 7 lock, and bits 5:4 are always 0.
- R2: A command with code 1 (set write-enable) sets bit 1 in the following cycle. A command with code 2 (clear write-enable) clears bit 1 in the following cycle.
- R3: A write-status command (code 4) takes effect only when the previous accepted command was arm-status-write (code 3). Cycles without `cmd_valid` do not break the pairing. Any other command, including an accepted write-status, disarms it. An unarmed write-status leaves the status byte unchanged.
- R4: When `wp_n` is low and bit 7 is 1, an armed write-status leaves bits 7 and 3:2 unchanged.
- R5: When `wp_n` is high or bit 7 is 0, an armed write-status copies `wr_data` bits 7 and 3:2 into the same status bit positions in the following cycle.
- R6: A write-status never changes bits 0, 1, 6 or 5:4. Bit 0 is set by `op_start` and cleared by `op_done`. Bit 6 is set by `aai_set` and cleared by `aai_clr`. The status byte stays visible while bit 0 is 1.
- R7: `op_done` clears bit 1 in the following cycle, unless a set-write-enable command arrives in the same cycle, in which case bit 1 ends at 1.
- R8: `addr_protected` is a combinational function of `addr` and the protection field. Field 00 protects nothing. Field 01 protects addresses whose two top bits are 11. Field 10 protects addresses whose top bit is 1. Field 11 protects every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command code is present this cycle |
| cmd_code | input | 3 | 0 other, 1 set write-enable, 2 clear write-enable, 3 arm status write, 4 write status |
| wr_data | input | 8 | Data byte for the write-status command |
| wp_n | input | 1 | Write-protect pin, active low |
| op_start | input | 1 | A program or erase operation begins |
| op_done | input | 1 | The running operation has completed |
| aai_set | input | 1 | Enter auto-increment programming mode |
| aai_clr | input | 1 | Leave auto-increment programming mode |
| addr | input | ADDR_W | Address to classify |
| status_out | output | 8 | Current status byte |
| addr_protected | output | 1 | `addr` lies in the protected region |

## Verification
Completion of an operation (`op_done`) and a set-write-enable command both write the write-enable latch, one clearing it and one setting it. The bench drives both in the same cycle, after the latch was already set and an operation was started. It expects the latch to read 1 and the busy bit to read 0 one cycle later. A following `op_done` on its own must then clear the latch, which shows that the clearing path still works when it does not collide.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

    typedef enum logic [2:0] {
        CMD_OTHER = 3'd0,
        CMD_WREN  = 3'd1,
        CMD_WRDI  = 3'd2,
        CMD_EWSR  = 3'd3,
        CMD_WRSR  = 3'd4
    } fsu_cmd_e;

    typedef struct packed {
        logic       lock;
        logic       aai;
        logic [1:0] spare;
        logic [1:0] bp;
        logic       wel;
        logic       busy;
    } fsu_status_t;

    localparam int STATUS_W = $bits(fsu_status_t);

    // Bits a status write may replace.
    localparam logic [STATUS_W-1:0] WR_MASK = 8'h8C;

    localparam fsu_status_t STATUS_RST = '{
        lock: 1'b1, aai: 1'b0, spare: 2'b00, bp: 2'b11, wel: 1'b0, busy: 1'b0
    };

    // Region test: only the two most significant address bits matter.
    function automatic logic in_region(input logic [1:0] bp, input logic [1:0] top2);
        case (bp)
            2'b00:   in_region = 1'b0;
            2'b01:   in_region = (top2 == 2'b11);
            2'b10:   in_region = top2[1];
            default: in_region = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/fsu_arm_gate.sv
module fsu_arm_gate
    import fsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  fsu_cmd_e   cmd,
    input  logic       wp_n,
    input  logic       lock,
    output logic       wr_accept,
    output logic       prot_writable
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (cmd_valid)
            armed <= (cmd == CMD_EWSR);
    end

    always_comb begin
        wr_accept     = cmd_valid && (cmd == CMD_WRSR) && armed;
        prot_writable = wp_n || !lock;
    end
endmodule

// File: rtl/fsu_status_reg.sv
module fsu_status_reg
    import fsu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                set_wel,
    input  logic                clr_wel,
    input  logic                op_start,
    input  logic                op_done,
    input  logic                aai_set,
    input  logic                aai_clr,
    input  logic                wr_accept,
    input  logic                prot_writable,
    input  logic [STATUS_W-1:0] wr_data,
    output fsu_status_t         st
);
    fsu_status_t st_n;

    always_comb begin
        st_n = st;
        if (wr_accept && prot_writable)
            st_n = fsu_status_t'((st & ~WR_MASK) | (wr_data & WR_MASK));
        // The latch clears on completion, but a same-cycle set wins.
        if (op_done) st_n.wel = 1'b0;
        if (clr_wel) st_n.wel = 1'b0;
        if (set_wel) st_n.wel = 1'b1;
        if (op_done)  st_n.busy = 1'b0;
        if (op_start) st_n.busy = 1'b1;
        if (aai_clr)  st_n.aai = 1'b0;
        if (aai_set)  st_n.aai = 1'b1;
        st_n.spare = 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= STATUS_RST;
        else     st <= st_n;
    end
endmodule

// File: rtl/fsu_prot_map.sv
module fsu_prot_map
    import fsu_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int TOP = ADDR_W - 1;

    logic [1:0] top2;

    always_comb begin
        top2 = addr[TOP -: 2];
        hit  = in_region(bp, top2);
    end

    // Only the two top address bits take part in the decision.
    logic unused_low;
    assign unused_low = ^addr[TOP-2:0];
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
    import fsu_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [7:0]        wr_data,
    input  logic              wp_n,
    input  logic              op_start,
    input  logic              op_done,
    input  logic              aai_set,
    input  logic              aai_clr,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        status_out,
    output logic              addr_protected
);
    fsu_cmd_e    cmd;
    fsu_status_t st;
    logic        wr_accept;
    logic        prot_writable;
    logic        set_wel;
    logic        clr_wel;

    always_comb begin
        cmd     = fsu_cmd_e'(cmd_code);
        set_wel = cmd_valid && (cmd == CMD_WREN);
        clr_wel = cmd_valid && (cmd == CMD_WRDI);
    end

    fsu_arm_gate u_gate (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .cmd           (cmd),
        .wp_n          (wp_n),
        .lock          (st.lock),
        .wr_accept     (wr_accept),
        .prot_writable (prot_writable)
    );

    fsu_status_reg u_reg (
        .clk           (clk),
        .rst           (rst),
        .set_wel       (set_wel),
        .clr_wel       (clr_wel),
        .op_start      (op_start),
        .op_done       (op_done),
        .aai_set       (aai_set),
        .aai_clr       (aai_clr),
        .wr_accept     (wr_accept),
        .prot_writable (prot_writable),
        .wr_data       (wr_data),
        .st            (st)
    );

    fsu_prot_map #(.ADDR_W(ADDR_W)) u_map (
        .bp   (st.bp),
        .addr (addr),
        .hit  (addr_protected)
    );

    assign status_out = st;
endmodule

// File: rtl/fsu_checker.sv
module fsu_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic [7:0]        wr_data,
    input logic              wp_n,
    input logic              op_start,
    input logic              op_done,
    input logic              aai_set,
    input logic              aai_clr,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        status_out,
    input logic              addr_protected
);
    logic prev_arm;
    logic quiet;

    always_ff @(posedge clk) begin
        if (rst)            prev_arm <= 1'b0;
        else if (cmd_valid) prev_arm <= (cmd_code == 3'd3);
    end

    assign quiet = !op_start && !op_done && !aai_set && !aai_clr;

    p_reset_value_r1: assert property (@(posedge clk)
        rst |=> status_out == 8'h8C);

    p_set_wel_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'd1) |=> status_out[1]);

    p_clr_wel_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'd2) |=> !status_out[1]);

    p_unarmed_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'd4 && !prev_arm && quiet) |=> $stable(status_out));

    p_locked_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'd4 && !wp_n && status_out[7])
        |=> ($stable(status_out[7]) && $stable(status_out[3:2])));

    p_readonly_bits_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'd4 && quiet)
        |=> ($stable(status_out[1:0]) && $stable(status_out[6])));

    p_spare_zero_r6: assert property (@(posedge clk) disable iff (rst)
        status_out[5:4] == 2'b00);

    p_done_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (op_done && !(cmd_valid && cmd_code == 3'd1)) |=> !status_out[1]);

    always_comb begin
        if (!rst && status_out[3:2] == 2'b11)
            a_full_region_r8: assert (addr_protected);
        if (!rst && status_out[3:2] == 2'b00)
            a_empty_region_r8: assert (!addr_protected);
    end
endmodule

bind flash_status_unit fsu_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_flash_status_unit.sv
`timescale 1ns/1ps
module sim_flash_status_unit;
    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_code = 3'd0;
    logic [7:0]        wr_data = 8'h00;
    logic              wp_n = 1'b1;
    logic              op_start = 1'b0;
    logic              op_done = 1'b0;
    logic              aai_set = 1'b0;
    logic              aai_clr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        status_out;
    logic              addr_protected;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    flash_status_unit #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .wr_data(wr_data), .wp_n(wp_n), .op_start(op_start), .op_done(op_done),
        .aai_set(aai_set), .aai_clr(aai_clr), .addr(addr),
        .status_out(status_out), .addr_protected(addr_protected)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One command for one cycle; results are sampled at the next falling edge.
    task automatic issue(input logic [2:0] code, input logic [7:0] data);
        cmd_valid = 1'b1;
        cmd_code  = code;
        wr_data   = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 3'd0;
    endtask

    task automatic pulse_op(input logic s, input logic d, input logic as, input logic ac);
        op_start = s; op_done = d; aai_set = as; aai_clr = ac;
        @(negedge clk);
        op_start = 1'b0; op_done = 1'b0; aai_set = 1'b0; aai_clr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check8("R1 reset status", status_out, 8'h8C);
    endtask

    task automatic t_wel();
        do_reset();
        issue(3'd1, 8'h00);
        check8("R2 set write-enable", status_out, 8'h8E);
        issue(3'd2, 8'h00);
        check8("R2 clear write-enable", status_out, 8'h8C);
    endtask

    task automatic t_arming();
        do_reset();
        wp_n = 1'b1;
        issue(3'd4, 8'h00);
        check8("R3 write without arm", status_out, 8'h8C);
        issue(3'd3, 8'h00);
        issue(3'd1, 8'h00);
        issue(3'd4, 8'h00);
        check8("R3 arm broken by other command", status_out, 8'h8E);
        issue(3'd3, 8'h00);
        @(negedge clk);
        @(negedge clk);
        issue(3'd4, 8'h00);
        check8("R3 idle cycles keep arm", status_out, 8'h02);
        issue(3'd4, 8'h8C);
        check8("R3 arm consumed by write", status_out, 8'h02);
    endtask

    task automatic t_lock();
        do_reset();
        wp_n = 1'b0;
        issue(3'd3, 8'h00);
        issue(3'd4, 8'h00);
        check8("R4 pin low and lock set", status_out, 8'h8C);
        wp_n = 1'b1;
        issue(3'd3, 8'h00);
        issue(3'd4, 8'h80);
        check8("R5 pin high writes", status_out, 8'h80);
        wp_n = 1'b0;
        issue(3'd3, 8'h00);
        issue(3'd4, 8'h0C);
        check8("R4 locked again", status_out, 8'h80);
        wp_n = 1'b1;
        issue(3'd3, 8'h00);
        issue(3'd4, 8'h00);
        wp_n = 1'b0;
        issue(3'd3, 8'h00);
        issue(3'd4, 8'h0C);
        check8("R5 lock clear with pin low writes", status_out, 8'h0C);
        wp_n = 1'b1;
    endtask

    task automatic t_readonly();
        do_reset();
        pulse_op(1'b1, 1'b0, 1'b1, 1'b0);
        check8("R6 busy and auto-increment set", status_out, 8'hCD);
        issue(3'd3, 8'h00);
        issue(3'd4, 8'h30);
        check8("R6 write keeps read-only bits", status_out, 8'h41);
        issue(3'd3, 8'h00);
        issue(3'd4, 8'hFF);
        check8("R6 write all ones", status_out, 8'hCD);
        pulse_op(1'b0, 1'b1, 1'b0, 1'b0);
        check8("R6 busy clears on done", status_out, 8'hCC);
        pulse_op(1'b0, 1'b0, 1'b0, 1'b1);
        check8("R6 auto-increment clear", status_out, 8'h8C);
    endtask

    task automatic t_collision();
        do_reset();
        issue(3'd1, 8'h00);
        pulse_op(1'b1, 1'b0, 1'b0, 1'b0);
        check8("R6 busy during operation", status_out, 8'h8F);
        op_done = 1'b1;
        issue(3'd1, 8'h00);
        op_done = 1'b0;
        check8("R7 done with set write-enable", status_out, 8'h8E);
        pulse_op(1'b0, 1'b1, 1'b0, 1'b0);
        check8("R7 done clears write-enable", status_out, 8'h8C);
    endtask

    task automatic probe(input string req, input logic [ADDR_W-1:0] a, input logic exp);
        addr = a;
        #1;
        check8(req, {7'd0, addr_protected}, {7'd0, exp});
    endtask

    task automatic t_decode();
        do_reset();
        probe("R8 field 11 low address", 20'h00000, 1'b1);
        wp_n = 1'b1;
        issue(3'd3, 8'h00);
        issue(3'd4, 8'h00);
        probe("R8 field 00 top address", 20'hFFFFF, 1'b0);
        issue(3'd3, 8'h00);
        issue(3'd4, 8'h04);
        probe("R8 field 01 quarter start", 20'hC0000, 1'b1);
        probe("R8 field 01 below quarter", 20'hBFFFF, 1'b0);
        issue(3'd3, 8'h00);
        issue(3'd4, 8'h08);
        probe("R8 field 10 half start", 20'h80000, 1'b1);
        probe("R8 field 10 below half", 20'h7FFFF, 1'b0);
    endtask

    initial begin
        t_reset();
        t_wel();
        t_arming();
        t_lock();
        t_readonly();
        t_collision();
        t_decode();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule